// File: doc/BRIEF.md
# MD5 / SHA-1 Message Padding Packer

This unit sits in front of an MD5 or SHA-1 compression core and turns a raw byte stream into the padded 32-bit word stream that the core consumes. Message bytes enter one per cycle on a valid/ready handshake. They are packed little-endian into 32-bit words, and a 64-bit counter keeps the total message length in bytes. Up to three trailing bytes are held across gaps in the input, so a message may arrive in bursts of any size.

A single-cycle `fin` strobe ends the message. The unit then emits the word that carries the 0x80 marker, merged into any pending partial word. Zero words follow until the stream sits at byte 56 of a 64-byte block, and then two length words close the block. The `sha_mode` input selects the byte order of the length field. The second length word carries `out_last`. The byte counter then restarts for the next message. A synchronous `clr` abandons a message at any point.

The control state machine has three states. `ST_FILL` accepts bytes and emits each completed word. `fin` moves it to `ST_PAD` and emits the marker word on the way. `ST_PAD` emits zero words. When the word position reaches 14 of 16 it emits the first length word and moves to `ST_LEN_HI`. `ST_LEN_HI` emits the second length word with the last flag and returns to `ST_FILL`. `clr` returns the machine to `ST_FILL` from any state.

Top module: `md_pad_packer`

## Requirements
- R1: Byte k (0..3) of each group of four accepted bytes lands in bits 8k+7:8k of an output word. The word is emitted once its fourth byte is accepted.
- R2: While fewer than four bytes are pending and no `fin` is accepted, no output word is produced for them.
- R3: When `fin` is accepted with n pending bytes (0..3), the next word holds those bytes, 0x80 at byte n and zero above it. With n = 0 this word is 0x00000080.
- R4: After the marker word, zero words are emitted until the position in the stream is 56 modulo 64 bytes, spilling into one more block when needed. A message of n bytes therefore yields ((n+8) div 64 + 1) × 16 words.
- R5: With `sha_mode` = 0 (MD5), the bit length (byte count × 8) is emitted as its low 32 bits and then its high 32 bits.
- R6: With `sha_mode` = 1 (SHA-1), the 64-bit bit length is emitted big-endian in stream byte order. The first word holds length bits 63:56 in its byte 0 down to bits 39:32 in its byte 3. The second word holds bits 31:24 in byte 0 down to bits 7:0 in byte 3.
- R7: `out_last` is high on the second length word only.
- R8: From the cycle `fin` is accepted until the last word is loaded, `in_ready` is low. A byte offered in the same cycle as `fin` is not accepted.
- R9: After reset, or after `clr`, nothing is pending: `out_valid` is low, `in_ready` is high, and the byte count and partial word are zero.
- R10: A zero-length message yields exactly one 16-word block.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R12: After the last word, the byte count restarts at zero, so consecutive messages are padded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of message state and output |
| sha_mode | input | 1 | 1 = SHA-1 length format, 0 = MD5 |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Byte (or `fin`) can be accepted |
| fin | input | 1 | End of message strobe, taken while `in_ready` would be high |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Packed or padding word |
| out_last | output | 1 | Final word of the padded message |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
The embedded assertions watch the cycle-level rules on every clock. They check that a stalled output word holds still, that the byte counter steps by one per accepted byte, and that a pending partial word is empty once its lane counter returns to zero. They also check that the second length word sits at the last word position of a block and that `in_ready` drops right after `fin` is taken.

Only the bench's scenarios can show the values carried by the words. These are the byte packing, the marker position for each count of leftover bytes, and the zero fill with its wrap into an extra block. They also include the two length byte orders, the word totals, the effect of `clr` mid-message and the independence of consecutive messages. The scoreboard compares these against a model of the padding rules, under both a free and a stalling downstream.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_PAD    = 2'd1,
        ST_LEN_HI = 2'd2
    } pad_state_t;

    localparam logic [7:0] MARK_BYTE = 8'h80;

endpackage

// File: rtl/mdp_byte_packer.sv
module mdp_byte_packer #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             flush,
    input  logic             take,
    input  logic [7:0]       din,
    output logic [1:0]       lane,
    output logic             word_done,
    output logic [31:0]      merged_word,
    output logic [31:0]      mark_word,
    output logic [CNT_W-1:0] byte_cnt
);
    import mdp_pkg::*;

    logic [31:0] pend;

    // Each lane takes either the incoming byte / marker or the held byte.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign merged_word[8*g +: 8] = (lane == 2'(g)) ? din       : pend[8*g +: 8];
        assign mark_word[8*g +: 8]   = (lane == 2'(g)) ? MARK_BYTE : pend[8*g +: 8];
    end

    assign word_done = take && (lane == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            lane     <= '0;
            byte_cnt <= '0;
        end else if (restart) begin
            pend     <= '0;
            lane     <= '0;
            byte_cnt <= '0;
        end else if (flush) begin
            pend <= '0;
            lane <= '0;
        end else if (take) begin
            byte_cnt <= byte_cnt + 1'b1;
            lane     <= lane + 2'd1;
            pend     <= (lane == 2'd3) ? '0 : merged_word;
        end
    end

    // R12
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !restart) |=> (byte_cnt == $past(byte_cnt) + 1'b1));

    // R2
    pend_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane == 2'd0) |-> (pend == '0));

endmodule

// File: rtl/mdp_len_fmt.sv
module mdp_len_fmt #(
    parameter int CNT_W = 64
) (
    input  logic             sha_mode,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic [31:0]      len_first,
    output logic [31:0]      len_second
);
    localparam int LEN_W = 64;

    logic [LEN_W-1:0] bits;
    logic [31:0]      be_hi;
    logic [31:0]      be_lo;

    assign bits = LEN_W'({byte_cnt, 3'b000});

    // Big-endian stream order: most significant length byte in lane 0.
    for (genvar g = 0; g < 4; g++) begin : g_swap
        assign be_hi[8*g +: 8] = bits[63-8*g -: 8];
        assign be_lo[8*g +: 8] = bits[31-8*g -: 8];
    end

    assign len_first  = sha_mode ? be_hi : bits[31:0];
    assign len_second = sha_mode ? be_lo : bits[63:32];

endmodule

// File: rtl/mdp_ctrl.sv
module mdp_ctrl #(
    parameter int BLOCK_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        fin,
    input  logic        in_valid,
    input  logic        out_ready,
    input  logic        word_done,
    input  logic [31:0] merged_word,
    input  logic [31:0] mark_word,
    input  logic [31:0] len_first,
    input  logic [31:0] len_second,
    output logic        in_ready,
    output logic        take,
    output logic        flush,
    output logic        restart,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_last
);
    import mdp_pkg::*;

    localparam int PW      = $clog2(BLOCK_WORDS);
    localparam int LEN_POS = BLOCK_WORDS - 2;

    pad_state_t    state, nxt;
    logic [PW-1:0] wpos;
    logic          slot_free;
    logic          load;
    logic [31:0]   ld_data;
    logic          ld_last;

    assign slot_free = !out_valid || out_ready;
    assign in_ready  = (state == ST_FILL) && slot_free && !fin && !clr;
    assign take      = in_ready && in_valid;

    always_comb begin
        nxt     = state;
        load    = 1'b0;
        ld_data = '0;
        ld_last = 1'b0;
        flush   = 1'b0;
        restart = clr;
        unique case (state)
            ST_FILL: begin
                if (slot_free && fin) begin
                    load    = 1'b1;
                    ld_data = mark_word;
                    flush   = 1'b1;
                    nxt     = ST_PAD;
                end else if (word_done) begin
                    load    = 1'b1;
                    ld_data = merged_word;
                end
            end
            ST_PAD: begin
                if (slot_free) begin
                    load = 1'b1;
                    if (wpos == PW'(LEN_POS)) begin
                        ld_data = len_first;
                        nxt     = ST_LEN_HI;
                    end
                end
            end
            ST_LEN_HI: begin
                if (slot_free) begin
                    load    = 1'b1;
                    ld_data = len_second;
                    ld_last = 1'b1;
                    restart = 1'b1;
                    nxt     = ST_FILL;
                end
            end
            default: nxt = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_FILL;
        else if (clr) state <= ST_FILL;
        else          state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            wpos      <= '0;
        end else if (clr) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            wpos      <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_last  <= ld_last;
            wpos      <= ld_last ? '0 : wpos + 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R7
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEN_HI) |-> (wpos == PW'(BLOCK_WORDS - 1)));

    // R8
    fin_block_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_FILL && fin && slot_free) |=> !in_ready);

endmodule

// File: rtl/md_pad_packer.sv
module md_pad_packer #(
    parameter int CNT_W       = 64,
    parameter int BLOCK_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        sha_mode,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        fin,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_last,
    input  logic        out_ready
);
    localparam int BLOCK_WORDS = BLOCK_BYTES / 4;

    logic             take, flush, restart, word_done;
    logic [1:0]       lane;
    logic [31:0]      merged_word, mark_word, len_first, len_second;
    logic [CNT_W-1:0] byte_cnt;

    mdp_byte_packer #(.CNT_W(CNT_W)) packer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .flush       (flush),
        .take        (take),
        .din         (in_data),
        .lane        (lane),
        .word_done   (word_done),
        .merged_word (merged_word),
        .mark_word   (mark_word),
        .byte_cnt    (byte_cnt)
    );

    mdp_len_fmt #(.CNT_W(CNT_W)) len_i (
        .sha_mode   (sha_mode),
        .byte_cnt   (byte_cnt),
        .len_first  (len_first),
        .len_second (len_second)
    );

    mdp_ctrl #(.BLOCK_WORDS(BLOCK_WORDS)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .fin         (fin),
        .in_valid    (in_valid),
        .out_ready   (out_ready),
        .word_done   (word_done),
        .merged_word (merged_word),
        .mark_word   (mark_word),
        .len_first   (len_first),
        .len_second  (len_second),
        .in_ready    (in_ready),
        .take        (take),
        .flush       (flush),
        .restart     (restart),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last)
    );

    // R9
    idle_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_valid && (lane == 2'd0) && (byte_cnt == '0)));

endmodule

// File: tb/md_pad_packer_tb.sv
module md_pad_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        sha_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        fin = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        out_ready = 1'b1;

    int checks = 0;
    int fails  = 0;
    int nwords = 0;
    logic       bp_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [32:0] q_word[$];
    string       q_tag[$];

    always #10 clk = ~clk;   // 50 MHz

    md_pad_packer dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sha_mode(sha_mode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .fin(fin),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mb(input int i, input int seed);
        return 8'((i * 7 + seed * 13 + 1) & 255);
    endfunction

    task automatic push(input logic [31:0] w, input bit last, input string tag);
        q_word.push_back({last, w});
        q_tag.push_back(tag);
    endtask

    // Expected padded stream for message bytes mb(0..n-1)
    task automatic exp_msg(input int n, input int seed, input bit sha);
        logic [31:0] w;
        logic [63:0] bits;
        int r, pos;
        for (int k = 0; k < n / 4; k++)
            push({mb(4*k+3, seed), mb(4*k+2, seed), mb(4*k+1, seed), mb(4*k, seed)}, 1'b0, "R1");
        r = n % 4;
        w = 32'h80 << (8 * r);
        for (int b = 0; b < r; b++) w[8*b +: 8] = mb(4*(n/4) + b, seed);
        push(w, 1'b0, "R3");
        pos = n / 4 + 1;
        while (pos % 16 != 14) begin
            push(32'h0, 1'b0, "R4");
            pos++;
        end
        bits = 64'(n) * 64'd8;
        if (sha) begin
            push({bits[39:32], bits[47:40], bits[55:48], bits[63:56]}, 1'b0, "R6");
            push({bits[7:0], bits[15:8], bits[23:16], bits[31:24]}, 1'b1, "R6");
        end else begin
            push(bits[31:0], 1'b0, "R5");
            push(bits[63:32], 1'b1, "R5");
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit acc;
        in_valid = 1'b1;
        in_data  = b;
        do begin
            @(negedge clk); acc = in_ready;
            @(posedge clk); #2;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic send_range(input int lo, input int hi, input int seed, input bit gap);
        for (int i = lo; i < hi; i++) begin
            send_byte(mb(i, seed));
            if (gap && (i % 5 == 2)) begin
                repeat (3) @(posedge clk);
                #2;
            end
        end
    endtask

    // fin with a competing byte; the byte must not be taken (R8)
    task automatic finish_msg();
        bit acc;
        fin = 1'b1; in_valid = 1'b1; in_data = 8'hEE;
        do begin
            @(negedge clk); acc = (dut_i.in_ready === 1'b0) && (out_valid === 1'b0 || out_ready === 1'b1);
            @(posedge clk); #2;
        end while (!acc);
        fin = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b0, "R8", 64'(in_ready), 64'd0);
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (q_word.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #2;
    endtask

    task automatic run_msg(input int n, input int seed, input bit sha, input bit gap,
                           input string cnt_tag);
        int base;
        sha_mode = sha;
        exp_msg(n, seed, sha);
        base = nwords;
        send_range(0, n, seed, gap);
        finish_msg();
        wait_drain();
        check((nwords - base) == (((n + 8) / 64) + 1) * 16, cnt_tag,
              64'(nwords - base), 64'((((n + 8) / 64) + 1) * 16));
    endtask

    // out_ready pattern
    initial begin
        forever begin
            @(posedge clk); #2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    // Scoreboard monitor, sampled at the falling edge
    logic        prev_stall = 1'b0;
    logic [32:0] held;
    always @(negedge clk) begin
        if (rst_n && !clr) begin
            if (prev_stall) // R11
                check(out_valid === 1'b1 && {out_last, out_data} === held, "R11",
                      64'({out_valid, out_last, out_data}), 64'({1'b1, held}));
            prev_stall = out_valid && !out_ready;
            held = {out_last, out_data};
            if (out_valid && out_ready) begin
                nwords++;
                if (q_word.size() == 0) begin
                    check(1'b0, "R7", 64'({out_last, out_data}), 64'd0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = q_word.pop_front();
                    t = q_tag.pop_front();
                    check(out_data === e[31:0], t, 64'(out_data), 64'(e[31:0]));
                    check(out_last === e[32], "R7", 64'(out_last), 64'(e[32]));
                end
            end
        end else begin
            prev_stall = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(out_valid === 1'b0 && in_ready === 1'b1, "R9",
              64'({out_valid, in_ready}), 64'b01);
        @(posedge clk); #2;

        // R10 zero length, MD5
        run_msg(0, 1, 1'b0, 1'b0, "R10");

        // R2 three bytes held back, then the final strobe
        sha_mode = 1'b0;
        exp_msg(3, 2, 1'b0);
        send_range(0, 3, 2, 1'b0);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R2", 64'(out_valid), 64'd0);
        @(posedge clk); #2;
        finish_msg();
        wait_drain();

        // R3 full word then marker alone; R12 back-to-back messages
        run_msg(4, 3, 1'b0, 1'b0, "R12");
        run_msg(6, 4, 1'b0, 1'b1, "R12");
        // R6 SHA-1, marker at word 13 then length right after
        run_msg(55, 5, 1'b1, 1'b1, "R4");
        // R4 wrap into an extra block
        run_msg(56, 6, 1'b1, 1'b0, "R4");
        // R11 with downstream stalls
        bp_en = 1'b1;
        run_msg(61, 7, 1'b0, 1'b1, "R4");
        run_msg(130, 8, 1'b1, 1'b0, "R5");
        run_msg(0, 9, 1'b1, 1'b0, "R10");

        // R9 clear mid-message: 5 bytes sent, one word out, one byte dropped
        push({mb(3, 10), mb(2, 10), mb(1, 10), mb(0, 10)}, 1'b0, "R1");
        send_range(0, 5, 10, 1'b0);
        wait_drain();
        clr = 1'b1;
        @(posedge clk); #2;
        clr = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R9",
              64'({out_valid, in_ready}), 64'b01);
        @(posedge clk); #2;
        run_msg(9, 11, 1'b0, 1'b1, "R9");

        bp_en = 1'b0;
        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule